// File: doc/BRIEF.md
# NOR Flash Page Emulator

This block is an on-chip storage array that copies the write rules of a serial NOR flash. A requester issues byte-program, page-erase and byte-read commands over a valid/ready request interface. A program can only pull bits low: the stored byte becomes the old byte AND the new data. Only an erase of the whole 256-byte page brings bits back to one. Firmware-style counters can therefore be built by clearing one more bit per program. Many programs may land in a page, at sequential or scattered addresses, with no erase between them.

Each page keeps a saturating count of the programs applied to it since its last erase. A debug port exposes the count, so a test can confirm that a page took the required number of programs (at least 512) between erases. Programs and erases take a fixed, parameterized number of cycles. While one is in progress the block reports busy and refuses new requests, so a read issued in that time waits until the operation completes. A one-cycle done pulse marks the end of each program or erase.

Top module: `nor_page_emu`

## Requirements
- R1: After reset every byte of the array reads as 8'hFF, every page program count is zero, busy is low and req_ready is high.
- R2: A completed program of data D at address A leaves the byte at A equal to its previous value AND D; a 1 in D never turns a stored 0 back to 1.
- R3: A completed erase sets all 256 bytes of the addressed page (page number = address bits above the low 8) to 8'hFF and leaves every other page unchanged.
- R4: A completed erase sets that page's program count to zero.
- R5: Each completed program adds one to its page's count; the count is CNT_W (10) bits wide and holds at 1023 once it gets there; dbg_count shows the count of the page selected by dbg_page.
- R6: An accepted program keeps busy high for PROG_LAT cycles and an accepted erase for ERASE_LAT cycles; in the cycle after busy falls, done is high for exactly that one cycle; req_ready is low whenever busy is high.
- R7: A read is accepted only while not busy; rd_valid is high, with the byte in rd_data, in the cycle after acceptance. A read held on the interface during a program stays stalled and then returns the byte as that program left it.
- R8: A page accepts at least 512 programs with no erase between them, and each byte reads back as expected after every single program, for both sequential bit-clearing counter steps and scattered addresses.
- R9: Command encoding on req_cmd: 2'd1 read, 2'd2 program, 2'd3 erase; code 2'd0 is ignored, leaving busy low, rd_valid low and the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_cmd | input | 2 | Command code (1 read, 2 program, 3 erase, 0 none) |
| req_addr | input | ADDR_W (10) | Byte address; upper bits select the page |
| req_data | input | 8 | Program data |
| req_ready | output | 1 | Request accepted at this edge when valid |
| busy | output | 1 | Program or erase in progress |
| done | output | 1 | One-cycle pulse after a program or erase completes |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| dbg_page | input | PG_W (2) | Page whose program count is shown |
| dbg_count | output | CNT_W (10) | Program count of the selected page |

## Verification
The hardest state to reach from the ports is a saturated page count, which needs over a thousand programs to one page with no erase. The bench first runs a 512-step bit-clearing counter through 64 bytes of one page, reading back after every step. It then adds a burst of scattered random programs to the same page until the count must stick at 1023, then erases the page and sweeps all of its bytes. The stalled read is produced by holding a read request on the interface during the busy window of a program to the same address.

// File: rtl/nor_emu_pkg.sv
package nor_emu_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_PROG  = 2'd2,
        CMD_ERASE = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_e;

    function automatic byte_t nor_merge(input byte_t stored, input byte_t incoming);
        return stored & incoming;
    endfunction

endpackage

// File: rtl/nor_emu_ctrl.sv
module nor_emu_ctrl
    import nor_emu_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int PROG_LAT  = 4,
    parameter int ERASE_LAT = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  byte_t             req_data,
    output logic              req_ready,
    output logic              busy,
    output logic              done,
    output logic              rd_fire,
    output logic              commit,
    output logic              commit_erase,
    output logic [ADDR_W-1:0] commit_addr,
    output byte_t             commit_data
);

    localparam int MAX_LAT = (ERASE_LAT > PROG_LAT) ? ERASE_LAT : PROG_LAT;
    localparam int LAT_W   = $clog2(MAX_LAT + 1);

    op_e               op_q;
    logic [LAT_W-1:0]  lat_q;
    logic [ADDR_W-1:0] addr_q;
    byte_t             data_q;
    logic              done_q;
    logic              fire;
    cmd_e              cmd;

    assign cmd       = cmd_e'(req_cmd);
    assign busy      = (op_q != OP_IDLE);
    assign req_ready = !busy;
    assign fire      = req_valid && req_ready;
    assign rd_fire   = fire && (cmd == CMD_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_IDLE;
            lat_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (op_q == OP_IDLE) begin
                if (fire && cmd == CMD_PROG) begin
                    op_q   <= OP_PROG;
                    lat_q  <= LAT_W'(PROG_LAT - 1);
                    addr_q <= req_addr;
                    data_q <= req_data;
                end else if (fire && cmd == CMD_ERASE) begin
                    op_q   <= OP_ERASE;
                    lat_q  <= LAT_W'(ERASE_LAT - 1);
                    addr_q <= req_addr;
                    data_q <= req_data;
                end
            end else if (lat_q == '0) begin
                op_q   <= OP_IDLE;
                done_q <= 1'b1;
            end else begin
                lat_q <= lat_q - LAT_W'(1);
            end
        end
    end

    assign done         = done_q;
    assign commit       = busy && (lat_q == '0);
    assign commit_erase = (op_q == OP_ERASE);
    assign commit_addr  = addr_q;
    assign commit_data  = data_q;

endmodule

// File: rtl/nor_emu_array.sv
module nor_emu_array
    import nor_emu_pkg::*;
#(
    parameter int PAGES   = 4,
    parameter int PAGE_AW = 8,
    localparam int PG_W   = $clog2(PAGES),
    localparam int ADDR_W = PG_W + PAGE_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_erase,
    input  logic [ADDR_W-1:0] wr_addr,
    input  byte_t             wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output byte_t             rd_byte
);

    localparam int PAGE_BYTES = 1 << PAGE_AW;

    logic [PG_W-1:0]    wr_page;
    logic [PAGE_AW-1:0] wr_off;
    logic [PAGE_AW-1:0] rd_off;
    byte_t              page_rd [PAGES];

    assign wr_page = wr_addr[ADDR_W-1:PAGE_AW];
    assign wr_off  = wr_addr[PAGE_AW-1:0];
    assign rd_off  = rd_addr[PAGE_AW-1:0];

    for (genvar g = 0; g < PAGES; g++) begin : g_page
        byte_t cells [PAGE_BYTES];
        logic  hit;

        assign hit = wr_en && (wr_page == PG_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < PAGE_BYTES; i++) cells[i] <= 8'hFF;
            end else if (hit) begin
                if (wr_erase) begin
                    for (int i = 0; i < PAGE_BYTES; i++) cells[i] <= 8'hFF;
                end else begin
                    cells[wr_off] <= nor_merge(cells[wr_off], wr_data);
                end
            end
        end

        assign page_rd[g] = cells[rd_off];
    end

    assign rd_byte = page_rd[rd_addr[ADDR_W-1:PAGE_AW]];

endmodule

// File: rtl/nor_emu_counters.sv
module nor_emu_counters #(
    parameter int PAGES = 4,
    parameter int CNT_W = 10,
    localparam int PG_W = $clog2(PAGES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_en,
    input  logic             ev_erase,
    input  logic [PG_W-1:0]  ev_page,
    input  logic [PG_W-1:0]  dbg_page,
    output logic [CNT_W-1:0] dbg_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt [PAGES];

    for (genvar g = 0; g < PAGES; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[g] <= '0;
            end else if (ev_en && ev_page == PG_W'(g)) begin
                if (ev_erase) begin
                    cnt[g] <= '0;
                end else if (cnt[g] != CNT_MAX) begin
                    cnt[g] <= cnt[g] + CNT_W'(1);
                end
            end
        end
    end

    assign dbg_count = cnt[dbg_page];

endmodule

// File: rtl/nor_page_emu.sv
module nor_page_emu
    import nor_emu_pkg::*;
#(
    parameter int PAGES     = 4,
    parameter int PAGE_AW   = 8,
    parameter int CNT_W     = 10,
    parameter int PROG_LAT  = 4,
    parameter int ERASE_LAT = 40,
    localparam int PG_W     = $clog2(PAGES),
    localparam int ADDR_W   = PG_W + PAGE_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    output logic              req_ready,
    output logic              busy,
    output logic              done,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    input  logic [PG_W-1:0]   dbg_page,
    output logic [CNT_W-1:0]  dbg_count
);

    logic              rd_fire;
    logic              commit;
    logic              commit_erase;
    logic [ADDR_W-1:0] commit_addr;
    byte_t             commit_data;
    logic [PG_W-1:0]   commit_page;
    byte_t             arr_rd;
    logic              rd_valid_q;
    byte_t             rd_data_q;

    assign commit_page = commit_addr[ADDR_W-1:PAGE_AW];

    nor_emu_ctrl #(
        .ADDR_W   (ADDR_W),
        .PROG_LAT (PROG_LAT),
        .ERASE_LAT(ERASE_LAT)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_cmd     (req_cmd),
        .req_addr    (req_addr),
        .req_data    (req_data),
        .req_ready   (req_ready),
        .busy        (busy),
        .done        (done),
        .rd_fire     (rd_fire),
        .commit      (commit),
        .commit_erase(commit_erase),
        .commit_addr (commit_addr),
        .commit_data (commit_data)
    );

    nor_emu_array #(
        .PAGES  (PAGES),
        .PAGE_AW(PAGE_AW)
    ) u_array (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (commit),
        .wr_erase(commit_erase),
        .wr_addr (commit_addr),
        .wr_data (commit_data),
        .rd_addr (req_addr),
        .rd_byte (arr_rd)
    );

    nor_emu_counters #(
        .PAGES(PAGES),
        .CNT_W(CNT_W)
    ) u_counters (
        .clk      (clk),
        .rst      (rst),
        .ev_en    (commit),
        .ev_erase (commit_erase),
        .ev_page  (commit_page),
        .dbg_page (dbg_page),
        .dbg_count(dbg_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= 8'hFF;
        end else begin
            rd_valid_q <= rd_fire;
            if (rd_fire) rd_data_q <= arr_rd;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;

endmodule

// File: rtl/nor_page_emu_chk.sv
module nor_page_emu_chk #(
    parameter int PG_W  = 2,
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             rd_valid,
    input logic             commit,
    input logic             commit_erase,
    input logic [PG_W-1:0]  commit_page,
    input logic [PG_W-1:0]  dbg_page,
    input logic [CNT_W-1:0] dbg_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_read_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !$past(busy));

    assert_erase_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (commit && commit_erase && commit_page == dbg_page)
        |=> (dbg_count == '0 || dbg_page != $past(dbg_page)));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        (commit && !commit_erase && commit_page == dbg_page)
        |=> (dbg_page != $past(dbg_page)) ||
            (($past(dbg_count) == CNT_MAX) ? (dbg_count == CNT_MAX)
                                            : (dbg_count == $past(dbg_count) + CNT_W'(1))));

endmodule

bind nor_page_emu nor_page_emu_chk #(
    .PG_W (PG_W),
    .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .done        (done),
    .rd_valid    (rd_valid),
    .commit      (commit),
    .commit_erase(commit_erase),
    .commit_page (commit_page),
    .dbg_page    (dbg_page),
    .dbg_count   (dbg_count)
);

// File: tb/nor_page_emu_tb.sv
module nor_page_emu_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PAGES      = 4;
    localparam int PAGE_AW    = 8;
    localparam int CNT_W      = 10;
    localparam int PROG_LAT   = 4;
    localparam int ERASE_LAT  = 40;
    localparam int PG_W       = 2;
    localparam int ADDR_W     = 10;
    localparam int NBYTES     = 1 << ADDR_W;
    localparam int CMAX       = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [1:0]        req_cmd = 2'd0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [7:0]        req_data = '0;
    logic              req_ready, busy, done, rd_valid;
    logic [7:0]        rd_data;
    logic [PG_W-1:0]   dbg_page = '0;
    logic [CNT_W-1:0]  dbg_count;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [7:0] model [NBYTES];
    int         mcnt  [PAGES];

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_page_emu #(
        .PAGES(PAGES), .PAGE_AW(PAGE_AW), .CNT_W(CNT_W),
        .PROG_LAT(PROG_LAT), .ERASE_LAT(ERASE_LAT)
    ) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_data(req_data), .req_ready(req_ready),
        .busy(busy), .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
        .dbg_page(dbg_page), .dbg_count(dbg_count)
    );

    function automatic logic [7:0] exp_prog(input logic [7:0] old, input logic [7:0] d);
        return old & d;
    endfunction

    function automatic int exp_cnt_inc(input int c);
        return (c >= CMAX) ? CMAX : c + 1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] cmd, input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0; req_cmd = 2'd0;
    endtask

    task automatic wait_op(input int lat, input bit timed, input string tag);
        int n = 0;
        while (busy) begin n++; @(negedge clk); end
        if (timed) begin
            chk({tag, " busy cycles"}, n, lat);
            chk({tag, " done pulse"}, done, 1);
            @(negedge clk);
            chk({tag, " done one cycle"}, done, 0);
        end
    endtask

    task automatic prog(input logic [ADDR_W-1:0] a, input logic [7:0] d, input bit timed);
        send(2'd2, a, d);
        wait_op(PROG_LAT, timed, "R6 program");
        model[a] = exp_prog(model[a], d);
        mcnt[a[ADDR_W-1:PAGE_AW]] = exp_cnt_inc(mcnt[a[ADDR_W-1:PAGE_AW]]);
    endtask

    task automatic erase(input int pg, input bit timed);
        send(2'd3, ADDR_W'(pg << PAGE_AW), 8'h00);
        wait_op(ERASE_LAT, timed, "R6 erase");
        for (int i = 0; i < (1 << PAGE_AW); i++) model[(pg << PAGE_AW) + i] = 8'hFF;
        mcnt[pg] = 0;
    endtask

    task automatic rd_chk(input logic [ADDR_W-1:0] a, input string tag);
        send(2'd1, a, 8'h00);
        chk({tag, " rd_valid"}, rd_valid, 1);
        chk({tag, " rd_data"}, rd_data, model[a]);
    endtask

    task automatic cnt_chk(input int pg, input string tag);
        @(negedge clk);
        dbg_page = PG_W'(pg);
        #1;
        chk(tag, dbg_count, mcnt[pg]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int stall;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < NBYTES; i++) model[i] = 8'hFF;
        for (int p = 0; p < PAGES; p++) mcnt[p] = 0;

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 ready", req_ready, 1);
        chk("R1 rd_valid", rd_valid, 0);
        rd_chk(10'h000, "R1 erased");
        rd_chk(10'h3FF, "R1 erased");
        for (int i = 0; i < 8; i++) rd_chk(ADDR_W'($urandom), "R1 erased");
        for (int p = 0; p < PAGES; p++) cnt_chk(p, "R1 count");

        // R2 AND merge, R6 timing
        prog(10'h005, 8'hA5, 1);
        rd_chk(10'h005, "R2 first program");
        chk("R2 literal", rd_data, 8'hA5);
        prog(10'h005, 8'h5A, 1);
        rd_chk(10'h005, "R2 and merge");
        chk("R2 literal", rd_data, 8'h00);
        prog(10'h005, 8'hFF, 1);
        rd_chk(10'h005, "R2 no set by program");
        cnt_chk(0, "R5 count after three");

        // R3 / R4 erase scope
        prog(10'h100, 8'h0F, 1);
        erase(0, 1);
        rd_chk(10'h005, "R3 erased byte");
        rd_chk(10'h0FF, "R3 erased byte");
        rd_chk(10'h100, "R3 other page kept");
        cnt_chk(0, "R4 count cleared");
        cnt_chk(1, "R4 other count kept");

        // R9 ignored command code
        @(negedge clk);
        req_valid = 1'b1; req_cmd = 2'd0; req_addr = 10'h100; req_data = 8'h00;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 no busy", busy, 0);
        chk("R9 no rd_valid", rd_valid, 0);
        rd_chk(10'h100, "R9 array unchanged");
        cnt_chk(1, "R9 count unchanged");

        // R7 stalled read
        send(2'd2, 10'h210, 8'h3C);
        req_valid = 1'b1; req_cmd = 2'd1; req_addr = 10'h210;
        stall = 0;
        while (!req_ready) begin
            if (rd_valid) chk("R7 rd_valid during stall", rd_valid, 0);
            stall++;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0; req_cmd = 2'd0;
        model[10'h210] = exp_prog(model[10'h210], 8'h3C);
        mcnt[2] = exp_cnt_inc(mcnt[2]);
        chk("R7 stall cycles", stall, PROG_LAT);
        chk("R7 rd_valid after stall", rd_valid, 1);
        chk("R7 data after stall", rd_data, 8'h3C);

        // R8 bit-clearing counter over 512 steps, no erase
        erase(1, 0);
        for (int k = 0; k < 512; k++) begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'(10'h100 + (k / 8));
            prog(a, ~(8'h01 << (k % 8)), 0);
            rd_chk(a, "R8 counter step");
        end
        cnt_chk(1, "R8 count at 512");
        // R8 scattered addresses, then R5 saturation
        for (int k = 0; k < 520; k++) begin
            logic [ADDR_W-1:0] a;
            a = {2'd1, 8'($urandom)};
            prog(a, 8'($urandom), 0);
            rd_chk(a, "R8 scattered");
        end
        cnt_chk(1, "R5 saturated");
        chk("R5 saturated literal", dbg_count, CMAX);
        erase(1, 1);
        for (int i = 0; i < 256; i++) rd_chk(ADDR_W'(10'h100 + i), "R3 full page sweep");
        cnt_chk(1, "R4 cleared after saturation");

        // random mix (R2, R3, R5)
        for (int k = 0; k < 600; k++) begin
            int r;
            logic [ADDR_W-1:0] a;
            r = int'($urandom % 20);
            a = ADDR_W'($urandom);
            if (r == 0) erase(int'($urandom % PAGES), 0);
            else if (r < 11) prog(a, 8'($urandom), 0);
            else rd_chk(a, "R2 random read");
        end
        for (int p = 0; p < PAGES; p++) cnt_chk(p, "R5 random count");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule